// File: doc/BRIEF.md
# Selectable Card Clock Divider

This block produces the clock driven onto a smart-card contact from the crystal input clock. Two select pins choose whether the card receives the input clock unchanged or divided by 2, 4 or 8. An enable from the activation sequencer starts and stops the card clock. While the enable is low, the output stays low.

The select pins are asynchronous to the crystal clock, so they pass through a two-stage synchronizer. A new ratio, a start or a stop is applied only at the end of a full output period. At that point both the old and the new waveform are low, so no runt pulse can appear. A start or a ratio change begins with one full low input cycle, and the new waveform then opens with its high phase. The pass-through ratio gates the input clock through a gate that is updated on the falling edge. The divided ratios come from a registered phase counter.

Top module: `card_clk_div`

## Requirements
- R1: While `rst_n` is low, and after reset for as long as `clk_en` has never been high, `card_clk` is low.
- R2: The synchronized select code sets the output period as follows: 2'b00 gives 8 input periods, 2'b01 gives 4, 2'b11 gives 2, and 2'b10 gives 1, in which case the input clock is passed through.
- R3: For the divided ratios, the high phase of `card_clk` lasts exactly half the output period. For pass-through, the output is high exactly while the input clock is high.
- R4: After `clk_en` goes low, `card_clk` finishes its current output period and then stays low. It is low no later than 9 input clock edges after the first edge that sees `clk_en` low.
- R5: `div_sel` goes through a two-flop synchronizer. After a change of `div_sel`, every `card_clk` period that starts later than 11 rising input edges after the change has the new length.
- R6: No high or low pulse on `card_clk` is shorter than half an input clock period. The divided path and the pass-through path are never active together.
- R7: When `clk_en` rises, the output stays low for one full input cycle. Its first rising edge comes exactly one input period after the first rising input edge that sees `clk_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal input clock, 2 MHz to 26 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Divide-ratio select code, asynchronous |
| clk_en | input | 1 | Card clock enable from the activation sequencer |
| card_clk | output | 1 | Clock to the card contact |

## Verification
The bench builds the block with its default parameters: a 3-bit phase counter covering ratios up to 8 and a two-stage select synchronizer. With this configuration, every select code and every one of the twelve ordered ratio changes can be swept in a few thousand cycles. Enable and disable are exercised at every ratio, with the disable landing at whatever phase the running waveform happens to be in. A time-stamped monitor checks the width of every card clock pulse across all of these changes. Output periods and high times are compared exactly, in picoseconds, against values computed from the ratio.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
    localparam int MAX_LOG2 = 3;
    localparam int CNT_W    = MAX_LOG2;
    localparam int LEN_W    = CNT_W + 1;

    // ratio encoded as log2 of the divisor
    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2,
        RATIO_8 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic             run;
        ratio_e           ratio;
        logic [CNT_W-1:0] cnt;
        logic             div_out;
        logic             pass_on;
    } phase_t;

    function automatic ratio_e sel_to_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return RATIO_8;
            2'b01:   return RATIO_4;
            2'b11:   return RATIO_2;
            default: return RATIO_1;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] ratio_len(input ratio_e r);
        return LEN_W'(1) << r;
    endfunction
endpackage

// File: rtl/ccd_sync.sv
`timescale 1ns/1ps
module ccd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/ccd_phase.sv
`timescale 1ns/1ps
module ccd_phase
    import ccd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_sync,
    input  logic       en,
    output logic       div_out,
    output logic       pass_on
);
    phase_t st_d, st_q;

    ratio_e           tgt;
    logic [LEN_W-1:0] len_cur, len_tgt, half_nxt;
    logic             at_end;

    always_comb begin
        st_d    = st_q;
        tgt     = sel_to_ratio(sel_sync);
        len_cur = ratio_len(st_q.ratio);
        len_tgt = ratio_len(tgt);
        at_end  = !st_q.run || (LEN_W'(st_q.cnt) == len_cur - LEN_W'(1));

        if (at_end) begin
            if (!en) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else if (!st_q.run || tgt != st_q.ratio) begin
                // commit: one low cycle, then the new waveform opens high
                st_d.run   = 1'b1;
                st_d.ratio = tgt;
                st_d.cnt   = CNT_W'(len_tgt - LEN_W'(1));
            end else begin
                st_d.cnt = '0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        half_nxt     = ratio_len(st_d.ratio) >> 1;
        st_d.div_out = st_d.run && (LEN_W'(st_d.cnt) < half_nxt);
        st_d.pass_on = st_d.run && (st_d.ratio == RATIO_1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b0, ratio: RATIO_8, cnt: '0, div_out: 1'b0, pass_on: 1'b0};
        else        st_q <= st_d;
    end

    assign div_out = st_q.div_out;
    assign pass_on = st_q.pass_on;
endmodule

// File: rtl/ccd_gate.sv
`timescale 1ns/1ps
module ccd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic div_out,
    input  logic pass_on,
    output logic clk_out
);
    logic gate_d, gate_q;

    always_comb gate_d = pass_on;

    // updated while the input clock is low, so the gated clock is never cut
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
    end

    assign clk_out = div_out | (clk & gate_q);
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/1ps
module card_clk_div #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_xtal,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       clk_en,
    output logic       card_clk
);
    logic [1:0] sel_sync;
    logic       ph_out;
    logic       ph_pass;

    ccd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk_xtal),
        .rst_n(rst_n),
        .din  (div_sel),
        .dout (sel_sync)
    );

    ccd_phase u_phase (
        .clk     (clk_xtal),
        .rst_n   (rst_n),
        .sel_sync(sel_sync),
        .en      (clk_en),
        .div_out (ph_out),
        .pass_on (ph_pass)
    );

    ccd_gate u_gate (
        .clk    (clk_xtal),
        .rst_n  (rst_n),
        .div_out(ph_out),
        .pass_on(ph_pass),
        .clk_out(card_clk)
    );
endmodule

// File: rtl/ccd_chk.sv
`timescale 1ns/1ps
module ccd_chk (
    input logic       clk_xtal,
    input logic       rst_n,
    input logic [1:0] div_sel,
    input logic       clk_en,
    input logic       card_clk,
    input logic       ph_out,
    input logic       ph_pass,
    input logic [1:0] sel_sync
);
    logic [3:0] since_rst_q, off_cnt_q, hi_run_q;

    always_ff @(posedge clk_xtal or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            off_cnt_q   <= '0;
            hi_run_q    <= '0;
        end else begin
            if (since_rst_q != 4'hf) since_rst_q <= since_rst_q + 1'b1;
            if (clk_en)                off_cnt_q <= '0;
            else if (off_cnt_q != 4'hf) off_cnt_q <= off_cnt_q + 1'b1;
            if (!ph_out)               hi_run_q <= '0;
            else if (hi_run_q != 4'hf)  hi_run_q <= hi_run_q + 1'b1;
        end
    end

    // R5: select reaches the phase logic two edges after the pin
    p_sync_delay_r5: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (since_rst_q >= 4'd2) |-> (sel_sync == $past(div_sel, 2)));

    // R4: a long disable leaves both paths and the pin low
    p_stop_low_r4: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (off_cnt_q >= 4'd9) |-> (!ph_out && !ph_pass && !card_clk));

    // R3: divided high phase never exceeds half of the longest period
    p_half_bound_r3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        hi_run_q <= 4'd4);

    // R6: only one source drives the card clock at a time
    p_one_src_r6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !(ph_out && ph_pass));
endmodule

bind card_clk_div ccd_chk u_chk (
    .clk_xtal(clk_xtal),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .clk_en  (clk_en),
    .card_clk(card_clk),
    .ph_out  (ph_out),
    .ph_pass (ph_pass),
    .sel_sync(sel_sync)
);

// File: tb/tb_card_clk_div.sv
`timescale 1ns/1ps
module tb_card_clk_div;
    logic       clk_xtal = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] div_sel  = 2'b00;
    logic       clk_en   = 1'b0;
    logic       card_clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  runts   = 0;
    bit  mon_on  = 1'b0;
    real last_edge = 0.0;

    card_clk_div dut (
        .clk_xtal(clk_xtal),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .clk_en  (clk_en),
        .card_clk(card_clk)
    );

    always #2.5 clk_xtal = ~clk_xtal;

    // R6: width of every pulse on the card clock
    always @(card_clk) begin
        if (mon_on && ($realtime - last_edge) < 2.49) runts++;
        last_edge = $realtime;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] code);
        case (code)
            2'b00:   return 8;
            2'b01:   return 4;
            2'b11:   return 2;
            default: return 1;
        endcase
    endfunction

    function automatic longint now_ps();
        return longint'($rtoi($realtime * 1000.0));
    endfunction

    task automatic measure(output longint per, output longint hi);
        longint t1, t2, t3;
        @(posedge card_clk); t1 = now_ps();
        @(negedge card_clk); t2 = now_ps();
        @(posedge card_clk); t3 = now_ps();
        per = t3 - t1;
        hi  = t2 - t1;
    endtask

    task automatic low_window(input int halves, output int highs);
        highs = 0;
        for (int k = 0; k < halves; k++) begin
            @(clk_xtal); #1;
            if (card_clk) highs++;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] codes [4];
        longint per, hi, t0, tr;
        int highs;
        codes = '{2'b00, 2'b01, 2'b11, 2'b10};

        // R1: low in reset and after reset while never enabled
        repeat (4) @(posedge clk_xtal);
        #1 chk(card_clk == 1'b0, "R1 in reset", card_clk, 0);
        @(negedge clk_xtal) rst_n = 1'b1;
        low_window(20, highs);
        chk(highs == 0, "R1 idle after reset", highs, 0);
        mon_on = 1'b1;

        // R7, R2, R3, R4 for every select code
        foreach (codes[i]) begin
            int n;
            n = div_of(codes[i]);
            @(negedge clk_xtal) div_sel = codes[i];
            repeat (4) @(posedge clk_xtal);
            @(negedge clk_xtal) begin clk_en = 1'b1; t0 = now_ps(); end
            @(posedge card_clk) tr = now_ps();
            chk(tr - t0 == 7500, "R7 first rise", tr - t0, 7500);
            measure(per, hi);
            chk(per == longint'(n) * 5000, "R2 period", per, longint'(n) * 5000);
            chk(hi == longint'(n) * 2500, "R3 high time", hi, longint'(n) * 2500);
            repeat (3) @(posedge clk_xtal);
            @(negedge clk_xtal) clk_en = 1'b0;
            repeat (9) @(posedge clk_xtal);
            low_window(16, highs);
            chk(highs == 0, "R4 stopped low", highs, 0);
        end

        // R5: every ordered ratio change
        @(negedge clk_xtal) clk_en = 1'b1;
        foreach (codes[i]) begin
            foreach (codes[j]) begin
                if (i != j) begin
                    int nt;
                    nt = div_of(codes[j]);
                    @(negedge clk_xtal) div_sel = codes[i];
                    repeat (14) @(posedge clk_xtal);
                    @(negedge clk_xtal) div_sel = codes[j];
                    repeat (11) @(posedge clk_xtal);
                    #1;
                    measure(per, hi);
                    chk(per == longint'(nt) * 5000, "R5 new period", per, longint'(nt) * 5000);
                end
            end
        end
        @(negedge clk_xtal) clk_en = 1'b0;
        repeat (12) @(posedge clk_xtal);

        chk(runts == 0, "R6 runt pulses", runts, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule